// File: doc/BRIEF.md
# Address-Programmable Signal Delay Line

This block delays a one-bit signal by a number of clock cycles that an address selects. The delay is a fixed base offset plus the address multiplied by a step size. The step size and the base offset are compile-time parameters counted in cycles. The input is sampled on every rising clock edge into a history register. The address needs no load strobe: the tap it picks is decoded combinationally from the live address pins. A new address therefore takes effect in the same cycle that it appears. Larger addresses always give longer delays.

Two copies of the delayed signal leave the block. The first is the true copy. The second is an inverted copy whose base delay is one cycle shorter. An active-low enable pin, when pulled high, parks the true output low and the inverted output high. While the enable is high, the history keeps filling as normal. A watch circuit raises a one-cycle flag whenever the sampled input ends a level that lasted less than the smallest pulse the line handles cleanly. That width is about six percent of the full-scale delay change.

There is no valid/ready handshake. The block samples a new input bit every cycle and cannot apply back-pressure, so a producer never stalls and any level shorter than one cycle is lost.

Top module: `addr_delay_line`

## Requirements
- R1: A synchronous active-high reset clears the history. From the first cycle after reset, `dout` reads 0 and `dout_n` reads 1 until input data sampled after reset reaches the selected tap. `short_pulse` reads 0.
- R2: With `en_n` low and the address held, a bit sampled on clock edge m appears on `dout` right after edge m+D, where D = TD0 + TINC*addr.
- R3: With `en_n` low, `dout_n` is the logical inverse of the bit sampled D-1 edges earlier. This makes its delay one cycle shorter than that of `dout`.
- R4: While `en_n` is 1, `dout` is forced to 0 and `dout_n` is forced to 1. Sampling goes on, so after `en_n` returns to 0 the outputs show the same history they would have shown with no disable.
- R5: The address is not latched. A change on `addr` moves both taps within the same cycle, before the next clock edge.
- R6: The delay range covers the endpoints: address 0 gives D = TD0, and address 255 gives D = TD0 + 255*TINC.
- R7: `short_pulse` goes high for one cycle right after an edge at which the sampled input differs from the previous sample, provided the level being left was held for fewer than MIN_W samples, where MIN_W = ceil(6*255*TINC/100). A level held exactly MIN_W samples does not flag. The first level change after reset never flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Signal to delay, sampled every cycle |
| addr | input | ADDR_W (8) | Live delay select, not latched |
| en_n | input | 1 | Active-low enable; high forces both outputs to rest levels |
| dout | output | 1 | Delayed true copy of `din` |
| dout_n | output | 1 | Delayed inverted copy, one cycle less base delay |
| short_pulse | output | 1 | One-cycle flag for an input level shorter than MIN_W |

## Verification
Several functions can land in the same cycle. An address change can coincide with a bit arriving at the old or the new tap. An enable toggle can also hit a cycle in which the narrow-pulse flag fires. The bench provokes these overlaps by moving `addr` and `en_n` at random points inside random input streams, with run lengths that straddle MIN_W. Each cycle is judged twice against a queue model of the sampled history: once just after the inputs change, to catch the live address decode, and once after the clock edge, for the registered history and the flag.

// File: rtl/dl_pkg.sv
`timescale 1ns/1ps
package dl_pkg;
  // Number of history stages needed to reach the largest tap.
  function automatic int unsigned dl_depth(input int unsigned td0,
                                           input int unsigned tinc,
                                           input int unsigned addr_w);
    return td0 + ((1 << addr_w) - 1) * tinc + 1;
  endfunction

  // Narrowest clean pulse: ceil(6% of the full-scale delay change).
  function automatic int unsigned dl_min_width(input int unsigned tinc,
                                               input int unsigned addr_w);
    return (6 * ((1 << addr_w) - 1) * tinc + 99) / 100;
  endfunction
endpackage

// File: rtl/dl_history.sv
`timescale 1ns/1ps
module dl_history #(
  parameter int unsigned DEPTH = 258
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  output logic [DEPTH-1:0] hist
);
  // hist[k] holds the bit sampled k edges before the most recent one.
  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= {hist[DEPTH-2:0], din};
  end
endmodule

// File: rtl/dl_tap.sv
`timescale 1ns/1ps
module dl_tap #(
  parameter int unsigned DEPTH  = 258,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned OFFSET = 2,
  parameter int unsigned STEP   = 1
) (
  input  logic [DEPTH-1:0]  hist,
  input  logic [ADDR_W-1:0] addr,
  output logic              tap
);
  localparam int unsigned IW = $clog2(DEPTH);
  logic [IW-1:0] idx;

  // Live decode: no register between the address pins and the tap select.
  always_comb begin
    idx = IW'(OFFSET) + IW'(STEP) * IW'(addr);
    tap = hist[idx];
  end
endmodule

// File: rtl/dl_pulse_watch.sv
`timescale 1ns/1ps
module dl_pulse_watch #(
  parameter int unsigned MIN_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic last_sample,
  output logic short_pulse
);
  localparam int unsigned CW = $clog2(MIN_W + 1);

  logic [CW-1:0] run_len;
  logic          armed;
  logic          level_change;
  logic          too_short;

  assign level_change = din ^ last_sample;
  assign too_short    = run_len < CW'(MIN_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len     <= '0;
      armed       <= 1'b0;
      short_pulse <= 1'b0;
    end else begin
      short_pulse <= level_change && armed && too_short;
      if (level_change) begin
        armed   <= 1'b1;
        run_len <= CW'(1);
      end else if (too_short) begin
        run_len <= run_len + CW'(1);
      end
    end
  end
endmodule

// File: rtl/addr_delay_line.sv
`timescale 1ns/1ps
module addr_delay_line #(
  parameter int unsigned TD0    = 2,
  parameter int unsigned TINC   = 1,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en_n,
  output logic              dout,
  output logic              dout_n,
  output logic              short_pulse
);
  localparam int unsigned DEPTH = dl_pkg::dl_depth(TD0, TINC, ADDR_W);
  localparam int unsigned MIN_W = dl_pkg::dl_min_width(TINC, ADDR_W);

  logic [DEPTH-1:0] hist;
  logic [1:0]       taps;

  dl_history #(.DEPTH(DEPTH)) u_hist (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .hist (hist)
  );

  // Tap 0 feeds the true output; tap 1 feeds the inverted output,
  // whose base offset is one stage shorter.
  for (genvar p = 0; p < 2; p++) begin : g_tap
    dl_tap #(
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W),
      .OFFSET (TD0 - p),
      .STEP   (TINC)
    ) u_tap (
      .hist (hist),
      .addr (addr),
      .tap  (taps[p])
    );
  end

  dl_pulse_watch #(.MIN_W(MIN_W)) u_watch (
    .clk         (clk),
    .rst         (rst),
    .din         (din),
    .last_sample (hist[0]),
    .short_pulse (short_pulse)
  );

  assign dout   = en_n ? 1'b0 : taps[0];
  assign dout_n = en_n ? 1'b1 : ~taps[1];
endmodule

// File: rtl/dl_checker.sv
`timescale 1ns/1ps
module dl_checker #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              din,
  input logic [ADDR_W-1:0] addr,
  input logic              en_n,
  input logic              dout,
  input logic              dout_n,
  input logic              short_pulse
);
  // R1: first cycle after reset shows rest levels and no flag
  a_r1_reset_rest: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dout && dout_n && !short_pulse));

  // R3: inverted tap leads the true tap by one stage
  a_r3_inverted_leads: assert property (@(posedge clk) disable iff (rst)
    !en_n |=> (en_n || (addr != $past(addr)) || (dout == !$past(dout_n))));

  // R4: disable parks the outputs
  a_r4_disable_forces: assert property (@(posedge clk) disable iff (rst)
    en_n |-> (!dout && dout_n));

  // R7: a flag only follows a change of the sampled level
  a_r7_flag_on_change: assert property (@(posedge clk) disable iff (rst)
    short_pulse |-> ($past(din) != $past(din, 2)));
endmodule

bind addr_delay_line dl_checker #(.ADDR_W(ADDR_W)) u_dl_checker (
  .clk         (clk),
  .rst         (rst),
  .din         (din),
  .addr        (addr),
  .en_n        (en_n),
  .dout        (dout),
  .dout_n      (dout_n),
  .short_pulse (short_pulse)
);

// File: tb/addr_delay_line_bench.sv
`timescale 1ns/1ps
module addr_delay_line_bench;
  localparam int TD0   = 2;
  localparam int TINC  = 1;
  localparam int DEPTH = TD0 + 255 * TINC + 1;
  localparam int MIN_W = (6 * 255 * TINC + 99) / 100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       din = 1'b0;
  logic [7:0] addr = 8'd0;
  logic       en_n = 1'b0;
  logic       dout, dout_n, short_pulse;

  int total = 0;
  int bad   = 0;
  string tag = "R1";

  // scoreboard: sampled history, newest first
  bit hq[$];
  bit prev_s;
  int run_s;
  bit armed_s;
  bit exp_flag;

  always #5 clk = ~clk;

  addr_delay_line #(.TD0(TD0), .TINC(TINC), .ADDR_W(8)) u_addr_delay_line (
    .clk(clk), .rst(rst), .din(din), .addr(addr), .en_n(en_n),
    .dout(dout), .dout_n(dout_n), .short_pulse(short_pulse)
  );

  function automatic bit tapv(input int i);
    if (i >= 0 && i < hq.size()) return hq[i];
    return 1'b0;
  endfunction

  function automatic bit exp_out(input logic [7:0] a, input bit e);
    if (e) return 1'b0;
    return tapv(TD0 + TINC * int'(a));
  endfunction

  function automatic bit exp_out_n(input logic [7:0] a, input bit e);
    if (e) return 1'b1;
    return !tapv(TD0 - 1 + TINC * int'(a));
  endfunction

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // driver: apply inputs, monitor: compare against the scoreboard
  task automatic step(input bit d, input logic [7:0] a, input bit e);
    @(negedge clk);
    din = d; addr = a; en_n = e;
    #1;
    chk({tag, " R5"}, dout,   exp_out(a, e),   "dout after live addr");
    chk({tag, " R3"}, dout_n, exp_out_n(a, e), "dout_n after live addr");
    @(posedge clk);
    exp_flag = (d != prev_s) && armed_s && (run_s < MIN_W);
    if (d != prev_s) begin armed_s = 1'b1; run_s = 1; end
    else if (run_s < MIN_W) run_s++;
    prev_s = d;
    hq.push_front(d);
    if (hq.size() > DEPTH) void'(hq.pop_back());
    #1;
    chk({tag, " R2"}, dout,        exp_out(a, e),   "dout after edge");
    chk({tag, " R3"}, dout_n,      exp_out_n(a, e), "dout_n after edge");
    chk({tag, " R7"}, short_pulse, exp_flag,        "short_pulse");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    hq.delete();
    prev_s = 1'b0; run_s = 0; armed_s = 1'b0; exp_flag = 1'b0;
    #1;
    chk("R1", dout, 1'b0, "dout after reset");
    chk("R1", dout_n, 1'b1, "dout_n after reset");
    chk("R1", short_pulse, 1'b0, "short_pulse after reset");
  endtask

  task automatic run_level(input bit d, input int n, input logic [7:0] a, input bit e);
    for (int i = 0; i < n; i++) step(d, a, e);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int flags_seen;
    void'($urandom(7));

    // R1: reset, then a high input must take D cycles to appear
    tag = "R1";
    do_reset();
    run_level(1'b1, 14, 8'd10, 1'b0);

    // R2: fixed address, wide pulses
    tag = "R2";
    for (int k = 0; k < 6; k++) run_level(k[0], 20, 8'd3, 1'b0);

    // R6: both ends of the address range
    tag = "R6";
    for (int k = 0; k < 4; k++) run_level(k[0], 20, 8'd0, 1'b0);
    for (int k = 0; k < 16; k++) run_level(k[0], 20, 8'd255, 1'b0);

    // R5: address moves mid-stream every few cycles
    tag = "R5";
    for (int k = 0; k < 60; k++) begin
      logic [7:0] a;
      a = 8'($urandom_range(0, 40));
      run_level(k[1], 3, a, 1'b0);
    end

    // R4: disable windows in a running stream, then resume
    tag = "R4";
    for (int k = 0; k < 12; k++) begin
      run_level(k[0], 18, 8'd7, k[1]);
      run_level(k[0], 2, 8'd7, ~k[1]);
    end

    // R7: widths MIN_W-1 (flag), MIN_W (no flag), 1 (flag)
    tag = "R7";
    flags_seen = 0;
    run_level(1'b0, 20, 8'd5, 1'b0);
    run_level(1'b1, MIN_W - 1, 8'd5, 1'b0);
    step(1'b0, 8'd5, 1'b0);
    if (short_pulse) flags_seen++;
    run_level(1'b0, MIN_W - 1, 8'd5, 1'b0);
    step(1'b1, 8'd5, 1'b0);
    if (short_pulse) flags_seen++;
    step(1'b0, 8'd5, 1'b0);
    if (short_pulse) flags_seen++;
    run_level(1'b0, 20, 8'd5, 1'b0);
    // the 15-wide and 1-wide levels flag, the 16-wide level does not
    chk("R7", flags_seen == 2, 1'b1, "count of boundary flags");

    // mixed random traffic: address, enable and narrow pulses together
    tag = "R5";
    for (int seg = 0; seg < 40; seg++) begin
      logic [7:0] a;
      bit lvl;
      a = 8'($urandom_range(0, 255));
      lvl = 1'b0;
      for (int r = 0; r < 4; r++) begin
        int n;
        n = $urandom_range(1, 25);
        lvl = ~lvl;
        for (int i = 0; i < n; i++) step(lvl, a, ($urandom_range(0, 15) == 0));
      end
    end

    // R1: a second reset mid-stream clears the history
    tag = "R1";
    do_reset();
    run_level(1'b1, 6, 8'd1, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule